// File: doc/BRIEF.md
# Linked-Descriptor DMA Chain Sequencer

A single-channel sequencer that walks a chain of link descriptors held in memory. Software writes the address of the first descriptor into the current-descriptor register and sets the start bit of the mode register. The block reads each 32-byte descriptor as four 64-bit words through a request/acknowledge read port. It hands the source address, destination address and byte count of the descriptor to an external data mover and waits for that mover's done pulse.

Each descriptor's next-link field carries two flag bits in its low bits beside a 32-byte-aligned pointer. One flag ends the chain. The other requests an end-of-segment event when that descriptor finishes. If neither stop condition applies, the sequencer masks the flags off the pointer and fetches the next descriptor. A zero byte count is a programming error and moves no data. An error reported by the mover halts the channel. An abort written by software also halts the channel.

Register map, by `reg_addr`: 0 mode, 1 status, 2 and 3 current-descriptor address (low and high word), 4 and 5 next-descriptor address (low and high word), 6 byte count. Reads of any other address return zero.

Top module: `link_dma_seq`

## Requirements
- R1: After reset the mode, status and byte-count registers read zero, `irq` is low, and neither `mem_req` nor `mv_req` is asserted.
- R2: A mode write that takes bit 0 (start) from 0 to 1 while the channel is idle fetches the descriptor at the current-descriptor address. The words are read at offsets +0 (source), +8 (destination), +16 (next link) and +24 (byte count, low 32 bits). The block then issues one mover request carrying those values.
- R3: When a descriptor completes without ending the chain, the current-descriptor register is loaded with its next-link field with the low 5 bits cleared, and fetching continues there. The next-descriptor register (addresses 4 and 5) reads the raw next-link field of the last descriptor fetched.
- R4: A descriptor whose next-link bit 0 is set ends the chain when it completes. Busy clears, halted stays clear, and the end-of-links status bit 5 sets.
- R5: A completed descriptor whose next-link bit 3 is set sets the end-of-segment status bit 4.
- R6: A descriptor with a zero byte count issues no mover request. It sets the programming-error status bit 3 and halted (bit 1), clears busy, and leaves the byte-count register reading zero.
- R7: A mover done pulse that comes with `mv_err` sets the transfer-error status bit 2 and halted, clears busy, and fetches nothing further. The current-descriptor register keeps the address of the failing descriptor.
- R8: A mode write with bit 1 (abort) set while busy drops `mem_req` and `mv_req` on the next cycle, clears busy and sets halted. Halted stays set until the next start.
- R9: Status bits 2 to 5 are cleared by writing ones to them. Zeros leave them unchanged, and bits 0 (busy) and 1 (halted) ignore writes.
- R10: `irq` is the OR of three enabled terms: mode bit 2 with (bit 2 or bit 3 of status), mode bit 3 with status bit 4, and mode bit 4 with status bit 5. When all three enables are clear, `irq` stays low.
- R11: While a mover request is pending, the byte-count register reads the descriptor's count. After a successful completion it reads zero.
- R12: Status bit 0 (busy) is set from start until the channel stops. `mem_req` and `mv_req` are never asserted together and only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr | output | 64 | Byte address of the requested descriptor word |
| mem_ack | input | 1 | Read acknowledge, one-cycle pulse with data |
| mem_rdata | input | 64 | Descriptor word returned |
| mv_req | output | 1 | Mover request, held until done |
| mv_src | output | 64 | Segment source address |
| mv_dst | output | 64 | Segment destination address |
| mv_len | output | 32 | Segment byte count |
| mv_done | input | 1 | Mover completion pulse |
| mv_err | input | 1 | Qualifies `mv_done` as a failed transfer |
| irq | output | 1 | Interrupt, level |

## Verification
The assertions assume that `mem_ack` pulses for one cycle and only while `mem_req` is high. They also assume that `mv_done` pulses only while `mv_req` is high, and that `mv_err` matters only alongside `mv_done`. The bench models memory and the mover as negative-edge responders that raise an acknowledge only against a pending request and drop it on the following cycle. A stall flag lets the bench hold a mover request open indefinitely, so that the mover never completes on its own while an abort is exercised. Register writes are placed only while the channel is idle, except for the abort write.

// File: rtl/link_dma_seq.sv
module link_dma_seq #(
  parameter int ADDR_W  = 64,
  parameter int CNT_W   = 32,
  parameter int REG_W   = 32,
  parameter int RA_W    = 3,
  parameter int ALIGN_B = 5,
  parameter int EOL_BIT = 0,
  parameter int EOS_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              mv_req,
  output logic [ADDR_W-1:0] mv_src,
  output logic [ADDR_W-1:0] mv_dst,
  output logic [CNT_W-1:0]  mv_len,
  input  logic              mv_done,
  input  logic              mv_err,
  output logic              irq
);
  localparam int HI_W = ADDR_W - REG_W;
  localparam logic [ADDR_W-1:0] PTR_MASK = ~((ADDR_W'(1) << ALIGN_B) - ADDR_W'(1));

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_MOVE} st_t;

  st_t               st;
  logic [1:0]        widx;
  logic [4:0]        mode;
  logic              halted;
  logic [3:0]        ev;
  logic [ADDR_W-1:0] cdar, ndar, src, dst;
  logic [CNT_W-1:0]  bcr;

  logic busy, wr_mode, start, kill;
  assign busy    = (st != S_IDLE);
  assign wr_mode = reg_wr && (reg_addr == RA_W'(0));
  assign start   = wr_mode && reg_wdata[0] && !mode[0] && !busy;
  assign kill    = wr_mode && reg_wdata[1] && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      widx   <= '0;
      mode   <= '0;
      halted <= 1'b0;
      ev     <= '0;
      cdar   <= '0;
      ndar   <= '0;
      src    <= '0;
      dst    <= '0;
      bcr    <= '0;
    end else begin
      if (wr_mode) mode <= reg_wdata[4:0];
      if (reg_wr && reg_addr == RA_W'(1)) ev <= ev & ~reg_wdata[5:2];
      if (reg_wr && reg_addr == RA_W'(2) && !busy) cdar[REG_W-1:0] <= reg_wdata;
      if (reg_wr && reg_addr == RA_W'(3) && !busy) cdar[ADDR_W-1:REG_W] <= reg_wdata[HI_W-1:0];
      if (kill) begin
        st     <= S_IDLE;
        halted <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st     <= S_FETCH;
            widx   <= '0;
            halted <= 1'b0;
          end
          S_FETCH: if (mem_ack) begin
            widx <= widx + 2'd1;
            case (widx)
              2'd0: src <= mem_rdata;
              2'd1: dst <= mem_rdata;
              2'd2: ndar <= mem_rdata;
              default: begin
                bcr <= mem_rdata[CNT_W-1:0];
                if (mem_rdata[CNT_W-1:0] == '0) begin
                  ev[1]  <= 1'b1;
                  halted <= 1'b1;
                  st     <= S_IDLE;
                end else begin
                  st <= S_MOVE;
                end
              end
            endcase
          end
          S_MOVE: if (mv_done) begin
            if (mv_err) begin
              ev[0]  <= 1'b1;
              halted <= 1'b1;
              st     <= S_IDLE;
            end else begin
              bcr <= '0;
              if (ndar[EOS_BIT]) ev[2] <= 1'b1;
              if (ndar[EOL_BIT]) begin
                ev[3] <= 1'b1;
                st    <= S_IDLE;
              end else begin
                cdar <= ndar & PTR_MASK;
                widx <= '0;
                st   <= S_FETCH;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req  = (st == S_FETCH);
  assign mem_addr = cdar + {{(ADDR_W-5){1'b0}}, widx, 3'b000};
  assign mv_req   = (st == S_MOVE);
  assign mv_src   = src;
  assign mv_dst   = dst;
  assign mv_len   = bcr;
  assign irq      = (mode[2] & (ev[0] | ev[1])) | (mode[3] & ev[2]) | (mode[4] & ev[3]);

  always_comb begin
    case (reg_addr)
      RA_W'(0): reg_rdata = {{(REG_W-5){1'b0}}, mode};
      RA_W'(1): reg_rdata = {{(REG_W-6){1'b0}}, ev, halted, busy};
      RA_W'(2): reg_rdata = cdar[REG_W-1:0];
      RA_W'(3): reg_rdata = REG_W'(cdar[ADDR_W-1:REG_W]);
      RA_W'(4): reg_rdata = ndar[REG_W-1:0];
      RA_W'(5): reg_rdata = REG_W'(ndar[ADDR_W-1:REG_W]);
      RA_W'(6): reg_rdata = REG_W'(bcr);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/link_dma_seq_chk.sv
module link_dma_seq_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_ack,
  input logic             mv_req,
  input logic             mv_done,
  input logic             mv_err,
  input logic [CNT_W-1:0] mv_len,
  input logic             irq,
  input logic             busy,
  input logic             halted,
  input logic             kill,
  input logic [2:0]       mode_ie
);
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mv_req));
  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || mv_req) |-> busy);
  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !kill) |=> mem_req);
  p_move_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && !mv_done && !kill) |=> mv_req);
  p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |-> (mv_len != '0));
  p_err_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && mv_done && mv_err) |=> (halted && !busy && !mem_req));
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!busy && halted && !mem_req && !mv_req));
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ie == 3'b000) |-> !irq);
endmodule

bind link_dma_seq link_dma_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mv_req(mv_req), .mv_done(mv_done), .mv_err(mv_err), .mv_len(mv_len),
  .irq(irq), .busy(busy), .halted(halted), .kill(kill), .mode_ie(mode[4:2])
);

// File: tb/link_dma_seq_tb.sv
`timescale 1ns/1ps
module link_dma_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_ack = 1'b0;
  logic [63:0] mem_addr, mem_rdata = '0;
  logic        mv_req, mv_done = 1'b0, mv_err = 1'b0, irq;
  logic [63:0] mv_src, mv_dst;
  logic [31:0] mv_len;

  logic [63:0] mem [0:127];
  logic [63:0] seg_src [0:15];
  logic [63:0] seg_dst [0:15];
  logic [31:0] seg_len [0:15];
  int  nseg = 0;
  bit  stall = 1'b0, err_flag = 1'b0;
  int  checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  link_dma_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
    .mv_done(mv_done), .mv_err(mv_err), .irq(irq)
  );

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:3]];
    end else mem_ack <= 1'b0;
    if (mv_req && !mv_done && !stall) begin
      mv_done <= 1'b1;
      mv_err  <= err_flag;
      seg_src[nseg[3:0]] <= mv_src;
      seg_dst[nseg[3:0]] <= mv_dst;
      seg_len[nseg[3:0]] <= mv_len;
      nseg <= nseg + 1;
    end else begin
      mv_done <= 1'b0;
      mv_err  <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(3'd1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic put_desc(input int base, input logic [63:0] s, input logic [63:0] d,
                          input logic [63:0] nx, input logic [31:0] n);
    mem[base/8]     = s;
    mem[base/8 + 1] = d;
    mem[base/8 + 2] = nx;
    mem[base/8 + 3] = {32'hdead_0000, n};
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 mode", v, 0);
    rd(3'd1, v); check("R1 status", v, 0);
    rd(3'd6, v); check("R1 bcr", v, 0);
    check("R1 irq/req", {irq, mem_req, mv_req}, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    put_desc(32'h40, 64'h1_0000_1000, 64'h2_0000_2000, 64'h80,  32'h40);
    put_desc(32'h80, 64'h1_0000_3000, 64'h2_0000_4000, 64'hC8,  32'h10);
    put_desc(32'hC0, 64'h1_0000_5000, 64'h2_0000_6000, 64'h5_0000_0101, 32'h1000);
    wr(3'd2, 32'h40); wr(3'd3, 0);
    wr(3'd0, 32'h1D);
    rd(3'd1, v); check("R12 busy after start", v[0], 1);
    wait_idle();
    check("R2 segment count", nseg, 3);
    check("R2 seg0 src", seg_src[0], 64'h1_0000_1000);
    check("R2 seg0 dst", seg_dst[0], 64'h2_0000_2000);
    check("R2 seg0 len", seg_len[0], 32'h40);
    check("R3 seg1 src", seg_src[1], 64'h1_0000_3000);
    check("R3 seg2 masked ptr", seg_src[2], 64'h1_0000_5000);
    check("R3 seg2 len", seg_len[2], 32'h1000);
    rd(3'd1, v); check("R4 R5 status eol+eos", v, 32'h30);
    rd(3'd2, v); check("R3 cdar masked", v, 32'hC0);
    rd(3'd4, v); check("R3 ndar raw lo", v, 32'h0000_0101);
    rd(3'd5, v); check("R3 ndar raw hi", v, 32'h5);
    rd(3'd6, v); check("R11 bcr after done", v, 0);
    check("R10 irq eol", irq, 1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(3'd1, 32'h13);
    rd(3'd1, v); check("R9 w1c eos only", v, 32'h20);
    check("R10 irq still eol", irq, 1);
    wr(3'd1, 32'h20);
    rd(3'd1, v); check("R9 w1c eol", v, 0);
    check("R10 irq cleared", irq, 0);
    wr(3'd0, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int n0;
    n0 = nseg;
    put_desc(32'h100, 64'h7000, 64'h8000, 64'h1, 32'h0);
    wr(3'd2, 32'h100);
    wr(3'd0, 32'h05);
    wait_idle();
    check("R6 no mover request", nseg, n0);
    rd(3'd1, v); check("R6 status pe+halted", v, 32'h0A);
    rd(3'd6, v); check("R6 bcr zero", v, 0);
    check("R10 irq err", irq, 1);
    wr(3'd1, 32'h08); wr(3'd0, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    put_desc(32'h140, 64'h9000, 64'hA000, 64'h9, 32'h4);
    wr(3'd2, 32'h140);
    wr(3'd0, 32'h01);
    wait_idle();
    rd(3'd1, v); check("R5 R4 status", v, 32'h30);
    check("R10 irq masked", irq, 0);
    wr(3'd0, 32'h09);
    rd(3'd1, v); check("R2 no restart while start held", v[0], 0);
    check("R10 irq eos enabled", irq, 1);
    wr(3'd1, 32'h30); wr(3'd0, 0);
  endtask

  task automatic t_err();
    logic [31:0] v;
    int n0;
    n0 = nseg;
    put_desc(32'h180, 64'hB000, 64'hC000, 64'h1A0, 32'h8);
    put_desc(32'h1A0, 64'hD000, 64'hE000, 64'h1, 32'h8);
    err_flag = 1'b1;
    wr(3'd2, 32'h180);
    wr(3'd0, 32'h05);
    wait_idle();
    err_flag = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 single segment", nseg, n0 + 1);
    rd(3'd1, v); check("R7 status te+halted", v, 32'h06);
    rd(3'd2, v); check("R7 cdar kept", v, 32'h180);
    check("R10 irq te", irq, 1);
    wr(3'd1, 32'h04); wr(3'd0, 0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    put_desc(32'h1C0, 64'hF000, 64'hF800, 64'h1, 32'h77);
    stall = 1'b1;
    wr(3'd2, 32'h1C0);
    wr(3'd0, 32'h01);
    for (int i = 0; i < 50 && !mv_req; i++) @(negedge clk);
    rd(3'd1, v); check("R12 busy in move", v, 32'h01);
    rd(3'd6, v); check("R11 bcr during move", v, 32'h77);
    wr(3'd0, 32'h02);
    check("R8 requests dropped", {mem_req, mv_req}, 0);
    rd(3'd1, v); check("R8 halted idle", v, 32'h02);
    wr(3'd0, 0);
    rd(3'd1, v); check("R8 halted persists", v, 32'h02);
    stall = 1'b0;
    wr(3'd0, 32'h01);
    wait_idle();
    rd(3'd1, v); check("R8 restart clears halted", v, 32'h20);
    wr(3'd1, 32'h20); wr(3'd0, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_chain();
    t_w1c();
    t_zero();
    t_mask();
    t_err();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule